// File: doc/BRIEF.md
# Single-Wire Bus Sleep and Wake Controller

This block is the digital mode and power-control logic of a single-wire bus transceiver. A host controller selects one of four operating modes on two mode pins. The analog front end supplies three comparator flags: bus dominant, bus at the high-voltage wake level, and loss of ground. The block decodes the mode and gates the inverted transmit path. It produces an open-drain-style receive output (pull low or release), a regulator-control output that powers the host, and a load-switch enable.

When the bus reaches the wake level while the device sleeps, the regulator-control output goes high. The receive output then follows the bus, so the powered-up host can see traffic. If the host does not select a non-sleep mode within a hold-off window, the block drops back to sleep. This happens even if the bus stays at the wake level. When the wake level goes away, the receive output stays active for a short linger window and is then released. Both windows are counted in clock cycles. A new wake edge restarts them.

The mode pins and the comparator flags pass through two-flop synchronizers. Transmit data is sampled in the block's own clock domain. A synchronous active-high reset puts the block in sleep.

Top module: `swbus_wake_ctrl`

## Requirements
- R1: `op_mode` reports the synchronized mode pins with the same codes: 00 sleep, 01 high-voltage wake-up, 10 high-speed, 11 normal.
- R2: After reset, `op_mode` is 00, `reg_ctrl` is 0, `rx_pull_low` is 0, `tx_drive_en` is 0 and `load_sw_en` is 1.
- R3: `tx_drive_en` is 1 only when `txd` is 0 and the mode is not sleep. `txd` = 1 (recessive) or sleep mode gives 0.
- R4: In any non-sleep mode, `rx_pull_low` is 1 while the bus is dominant (`bus_dom` or `bus_hv` high) and 0 while the bus is recessive.
- R5: In sleep mode with no wake event pending, `rx_pull_low` stays 0 whatever the bus state.
- R6: A rising edge of `bus_hv` in sleep mode sets `reg_ctrl` to 1 and makes `rx_pull_low` follow the bus.
- R7: After `bus_hv` falls in sleep mode, `rx_pull_low` keeps following the bus for `RX_LINGER` cycles and is then released. If the host has selected a non-sleep mode, it keeps following the bus.
- R8: `reg_ctrl` is 1 whenever `op_mode` is not sleep.
- R9: In sleep mode, `reg_ctrl` returns to 0 `WAKE_HOLD` cycles after the last wake edge, even while `bus_hv` stays high. `rx_pull_low` is released `RX_LINGER` cycles later.
- R10: `load_sw_en` is 0 while loss of ground is flagged and 1 otherwise, in every mode.
- R11: A new rising edge of `bus_hv` during the hold-off window restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pin | input | 2 | Host mode selection (asynchronous) |
| txd | input | 1 | Transmit data, 0 drives the bus |
| bus_dom | input | 1 | Comparator: bus dominant at normal level |
| bus_hv | input | 1 | Comparator: bus at high-voltage wake level |
| gnd_lost | input | 1 | Comparator: loss of ground detected |
| op_mode | output | 2 | Decoded operating mode |
| tx_drive_en | output | 1 | Transmitter drives the bus dominant |
| rx_pull_low | output | 1 | 1 pulls the receive pin low, 0 releases it |
| reg_ctrl | output | 1 | Regulator enable for the host supply |
| load_sw_en | output | 1 | Load switch closed |

## Verification
A vector table walks every mode code against combinations of transmit data, bus dominance and ground loss. It shows apart the gating by sleep, the transmit inversion, the receive polarity and the load switch's independence of mode. Directed sequences cover the wake paths. A short wake pulse with the bus dominant separates the receive linger window from a plain release. The same pulse followed by a host switch to normal mode shows that the release is cancelled. A wake level held far past the hold-off shows that the fall back to sleep does not wait for the bus. A second wake edge inside the window shows that the expiry moves out.

// File: rtl/swbus_pkg.sv
package swbus_pkg;

    typedef enum logic [1:0] {
        MODE_SLEEP  = 2'b00,
        MODE_HVWAKE = 2'b01,
        MODE_HSPEED = 2'b10,
        MODE_NORMAL = 2'b11
    } swb_mode_e;

    typedef struct packed {
        swb_mode_e mode;
        logic      tx_en;
        logic      bus_low;
        logic      gnd_ok;
        logic      hv_prev;
    } swb_state_t;

endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg_q[gi] <= '0;
                    else     stg_q[gi] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg_q[gi] <= '0;
                    else     stg_q[gi] <= stg_q[gi-1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/swb_downcnt.sv
module swb_downcnt #(
    parameter int LOAD_VAL = 16,
    localparam int CW      = $clog2(LOAD_VAL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          clr,
    output logic [CW-1:0] value,
    output logic          busy
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)               cnt_d = '0;
        else if (load)         cnt_d = CW'(LOAD_VAL);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign value = cnt_q;
    assign busy  = (cnt_q != '0);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !clr && value == '0) |=> (value == '0));
endmodule

// File: rtl/swbus_wake_ctrl.sv
module swbus_wake_ctrl
    import swbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_HOLD   = 1000,
    parameter int RX_LINGER   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_pin,
    input  logic       txd,
    input  logic       bus_dom,
    input  logic       bus_hv,
    input  logic       gnd_lost,
    output logic [1:0] op_mode,
    output logic       tx_drive_en,
    output logic       rx_pull_low,
    output logic       reg_ctrl,
    output logic       load_sw_en
);
    localparam int NSYNC = 5;
    localparam int WCW   = $clog2(WAKE_HOLD + 1);
    localparam int RCW   = $clog2(RX_LINGER + 1);

    logic [NSYNC-1:0] raw_in, syn_in;
    logic [1:0]       s_mode;
    logic             s_dom, s_hv, s_gnd;

    assign raw_in = {mode_pin, bus_dom, bus_hv, gnd_lost};

    swb_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    assign {s_mode, s_dom, s_hv, s_gnd} = syn_in;

    swb_state_t st_d, st_q;
    logic       sleep_sel, hv_rise;
    logic       wake_load, rx_load, rx_clr;
    logic       wake_busy, rx_busy;
    logic [WCW-1:0] wake_val;
    logic [RCW-1:0] rx_val;

    swb_downcnt #(.LOAD_VAL(WAKE_HOLD)) u_wake_cnt (
        .clk   (clk),
        .rst   (rst),
        .load  (wake_load),
        .clr   (1'b0),
        .value (wake_val),
        .busy  (wake_busy)
    );

    swb_downcnt #(.LOAD_VAL(RX_LINGER)) u_rx_cnt (
        .clk   (clk),
        .rst   (rst),
        .load  (rx_load),
        .clr   (rx_clr),
        .value (rx_val),
        .busy  (rx_busy)
    );

    always_comb begin
        sleep_sel = (swb_mode_e'(s_mode) == MODE_SLEEP);
        hv_rise   = s_hv && !st_q.hv_prev;
        // host in control, or a fresh wake edge: (re)open the hold-off window
        wake_load = !sleep_sel || hv_rise;
        // in sleep the receiver listens only while a wake is being honoured
        rx_load   = sleep_sel && s_hv && (hv_rise || wake_busy);
        rx_clr    = !sleep_sel;

        st_d         = st_q;
        st_d.mode    = swb_mode_e'(s_mode);
        st_d.tx_en   = !txd && !sleep_sel;
        st_d.bus_low = s_dom || s_hv;
        st_d.gnd_ok  = !s_gnd;
        st_d.hv_prev = s_hv;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode    <= MODE_SLEEP;
            st_q.tx_en   <= 1'b0;
            st_q.bus_low <= 1'b0;
            st_q.gnd_ok  <= 1'b1;
            st_q.hv_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_mode     = st_q.mode;
    assign tx_drive_en = st_q.tx_en;
    assign reg_ctrl    = wake_busy;
    assign load_sw_en  = st_q.gnd_ok;
    assign rx_pull_low = ((st_q.mode != MODE_SLEEP) || rx_busy) && st_q.bus_low;

    // R6
    wake_raises_reg_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(s_hv) |=> reg_ctrl);

    // R8
    awake_mode_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (op_mode != MODE_SLEEP) |-> reg_ctrl);

    // R9
    reg_drop_in_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(reg_ctrl) |-> (op_mode == MODE_SLEEP));

    // R3
    sleep_no_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (op_mode == MODE_SLEEP) |-> !tx_drive_en);

    // R10
    gnd_loss_open_chk: assert property (@(posedge clk) disable iff (rst)
        s_gnd |=> !load_sw_en);

    // R7
    rx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (op_mode == MODE_SLEEP && rx_val == '0) |-> !rx_pull_low);
endmodule

// File: tb/tb_swbus_wake_ctrl.sv
`timescale 1ns/1ps
module tb_swbus_wake_ctrl;
    localparam int WH = 20;
    localparam int RL = 6;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode_pin;
    logic       txd, bus_dom, bus_hv, gnd_lost;
    logic [1:0] op_mode;
    logic       tx_drive_en, rx_pull_low, reg_ctrl, load_sw_en;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    swbus_wake_ctrl #(.SYNC_STAGES(2), .WAKE_HOLD(WH), .RX_LINGER(RL)) dut (
        .clk(clk), .rst(rst), .mode_pin(mode_pin), .txd(txd),
        .bus_dom(bus_dom), .bus_hv(bus_hv), .gnd_lost(gnd_lost),
        .op_mode(op_mode), .tx_drive_en(tx_drive_en),
        .rx_pull_low(rx_pull_low), .reg_ctrl(reg_ctrl), .load_sw_en(load_sw_en)
    );

    // {mode, txd, dom, gnd, exp_mode, exp_tx, exp_rx, exp_ld}
    localparam logic [9:0] VEC [8] = '{
        {2'b11, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 1'b1},
        {2'b11, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 1'b1, 1'b1},
        {2'b10, 1'b0, 1'b1, 1'b0, 2'b10, 1'b1, 1'b1, 1'b1},
        {2'b01, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0},
        {2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1},
        {2'b00, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0},
        {2'b11, 1'b0, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1, 1'b0},
        {2'b01, 1'b0, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1500000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; mode_pin = 2'b00; txd = 1'b1;
        bus_dom = 1'b0; bus_hv = 1'b0; gnd_lost = 1'b0;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        // R2 reset state
        chk("R2 mode", op_mode, 2'b00);
        chk("R2 reg", {1'b0, reg_ctrl}, 2'b00);
        chk("R2 rx", {1'b0, rx_pull_low}, 2'b00);
        chk("R2 tx", {1'b0, tx_drive_en}, 2'b00);
        chk("R2 load", {1'b0, load_sw_en}, 2'b01);

        // table walk: R1 R3 R4 R5 R8 R10
        for (int i = 0; i < 8; i++) begin
            {mode_pin, txd, bus_dom, gnd_lost} = VEC[i][9:5];
            wait_n(4);
            chk("R1 mode", op_mode, VEC[i][4:3]);
            chk("R3 tx", {1'b0, tx_drive_en}, {1'b0, VEC[i][2]});
            chk((VEC[i][9:8] == 2'b00) ? "R5 rx" : "R4 rx", {1'b0, rx_pull_low}, {1'b0, VEC[i][1]});
            chk("R10 load", {1'b0, load_sw_en}, {1'b0, VEC[i][0]});
            if (VEC[i][9:8] != 2'b00)
                chk("R8 reg", {1'b0, reg_ctrl}, 2'b01);
        end

        // back to sleep, let windows expire
        mode_pin = 2'b00; bus_dom = 1'b1; gnd_lost = 1'b0; txd = 1'b0;
        wait_n(WH + 6);
        chk("R9 reg idle", {1'b0, reg_ctrl}, 2'b00);
        chk("R5 rx sleep dom", {1'b0, rx_pull_low}, 2'b00);

        // R6: wake pulse with dominant bus, R7 linger then release
        bus_hv = 1'b1;
        wait_n(4);
        chk("R6 reg", {1'b0, reg_ctrl}, 2'b01);
        chk("R6 rx follows", {1'b0, rx_pull_low}, 2'b01);
        chk("R3 tx sleep", {1'b0, tx_drive_en}, 2'b00);
        wait_n(4);
        bus_hv = 1'b0;
        wait_n(3);
        chk("R7 rx linger", {1'b0, rx_pull_low}, 2'b01);
        wait_n(RL + 1);
        chk("R7 rx released", {1'b0, rx_pull_low}, 2'b00);
        wait_n(WH + 4);
        chk("R9 reg dropped", {1'b0, reg_ctrl}, 2'b00);

        // R7: host takes control during linger window
        bus_hv = 1'b1;
        wait_n(5);
        bus_hv = 1'b0;
        mode_pin = 2'b11;
        wait_n(RL + WH + 10);
        chk("R7 rx kept", {1'b0, rx_pull_low}, 2'b01);
        chk("R8 reg kept", {1'b0, reg_ctrl}, 2'b01);
        bus_dom = 1'b0;
        wait_n(4);
        chk("R4 rx recessive", {1'b0, rx_pull_low}, 2'b00);

        // R9: wake held high, still falls back to sleep
        mode_pin = 2'b00; bus_dom = 1'b0;
        wait_n(WH + RL + 8);
        bus_hv = 1'b1;
        wait_n(3 + WH - 2);
        chk("R9 reg before expiry", {1'b0, reg_ctrl}, 2'b01);
        wait_n(3);
        chk("R9 reg expired hv high", {1'b0, reg_ctrl}, 2'b00);
        wait_n(RL + 2);
        chk("R9 rx released hv high", {1'b0, rx_pull_low}, 2'b00);
        bus_hv = 1'b0;
        wait_n(WH + RL + 8);

        // R11: second wake edge restarts hold-off
        bus_hv = 1'b1;
        wait_n(WH - 6);
        bus_hv = 1'b0;
        wait_n(3);
        bus_hv = 1'b1;
        wait_n(12);
        chk("R11 reg restarted", {1'b0, reg_ctrl}, 2'b01);
        wait_n(WH);
        chk("R11 reg expired", {1'b0, reg_ctrl}, 2'b00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule